// File: doc/BRIEF.md
# Display Link Reset Sequencer

This block brings a serial display host controller out of reset in stages and puts it back into reset in the reverse order. It owns four active-high reset outputs: the register-access domain, the escape-clock domain, the byte-clock domain and the pixel-input domain. It also drives an enable for an auxiliary pixel-source clock, an enable for the transmit escape clock, and an enable request for the PHY. Bring-up is gated by two one-cycle handshakes. A register-programming agent pulses `cfg_done` once the controller and PHY are set up. A command agent pulses `cmd_done` once the attached panel has received its configuration commands.

All pins are plain control and status levels or pulses. There is no data stream and no back-pressure. A request or handshake that arrives out of turn changes nothing. It raises a one-cycle `order_err` pulse instead. A handshake that arrives inside its window but before the minimum spacing has elapsed is remembered. It takes effect as soon as the spacing is met.

Top module: `dlink_rst_seq`

## Requirements
- R1: During and right after reset, all four reset outputs are high. `aux_clk_en`, `esc_clk_en`, `phy_en`, `ready` and `order_err` are low.
- R2: An `en_req` pulse in the idle state (with `dis_req` low) clears only `rst_reg` on the next cycle. In that same cycle `aux_clk_en`, `esc_clk_en` and `phy_en` go high.
- R3: `rst_esc` falls max(G, i+1) cycles after `rst_reg` fell. Here G is the effective step spacing and i is the cycle index (0 = first cycle with `rst_reg` low) in which `cfg_done` was pulsed.
- R4: `rst_byte` falls exactly G cycles after `rst_esc` fell.
- R5: `rst_pix` falls max(G, j+1) cycles after `rst_byte` fell, where j indexes the `cmd_done` pulse in the same way. It is the last reset to be released.
- R6: The effective spacing G equals `step_gap` when that is nonzero. A `step_gap` of 0 selects the default of 4 cycles.
- R7: A `dis_req` while running sets `rst_pix` and clears `phy_en` in the first cycle. `rst_byte` is set in the second cycle. `rst_esc` is set and `esc_clk_en` cleared in the third, so the PHY is off before the escape clock stops. `rst_reg` is set in the fourth.
- R8: `aux_clk_en` is high in every cycle from the first release through the cycle in which `rst_reg` is set again. It drops only on the return to idle.
- R9: The following are ignored: `en_req` outside idle or together with `dis_req`, `dis_req` in idle or during teardown, `cfg_done` outside the configuration wait, and `cmd_done` outside the command wait. Each one leaves all outputs unchanged and raises `order_err` for exactly one cycle, on the cycle after it. A stray handshake is not remembered.
- R10: `ready` is high only while all four reset outputs are low.
- R11: A `dis_req` in any bring-up state starts the teardown. A reset already asserted is never released on the way down. Idle (`aux_clk_en` low, all resets high) is reached in the fifth cycle after the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | Bring-up request pulse |
| dis_req | input | 1 | Teardown request pulse |
| cfg_done | input | 1 | Controller and PHY setup complete pulse |
| cmd_done | input | 1 | Panel command phase complete pulse |
| step_gap | input | GAP_W | Minimum cycles between release steps, 0 selects the default |
| rst_reg | output | 1 | Register-access domain reset, active high |
| rst_esc | output | 1 | Escape-clock domain reset, active high |
| rst_byte | output | 1 | Byte-clock domain reset, active high |
| rst_pix | output | 1 | Pixel-input domain reset, active high |
| aux_clk_en | output | 1 | Auxiliary pixel-source clock enable |
| esc_clk_en | output | 1 | Transmit escape clock enable |
| phy_en | output | 1 | PHY power enable request |
| ready | output | 1 | All domains out of reset |
| order_err | output | 1 | One-cycle pulse flagging an ignored request |

## Verification
The assertions check the following on every cycle:
- each release only follows the release of the domain before it, and each reassertion only follows those after it;
- the PHY enable is down before the escape clock stops;
- the auxiliary clock covers every non-idle cycle, and `ready` never coexists with an asserted reset;
- teardown ends in idle, and misplaced enables are flagged.

Only the bench scenarios can show the exact spacing of each step across the sweep of gap settings and handshake delays, including the default-gap selection. The same holds for the cycle-exact teardown pattern from both a running and a half-started link, and for a stray handshake being forgotten rather than latched.

// File: rtl/dls_pkg.sv
`timescale 1ns/1ps
package dls_pkg;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_CFG   = 4'd1,
    ST_ESC   = 4'd2,
    ST_BYTE  = 4'd3,
    ST_RUN   = 4'd4,
    ST_DPIX  = 4'd5,
    ST_DBYTE = 4'd6,
    ST_DESC  = 4'd7,
    ST_DREG  = 4'd8
  } seq_state_e;

  typedef struct packed {
    logic rst_reg;
    logic rst_esc;
    logic rst_byte;
    logic rst_pix;
    logic aux_en;
    logic esc_clk_en;
    logic phy_en;
    logic ready;
  } seq_out_t;

  localparam int HS_COUNT = 2;

  localparam seq_out_t OUT_IDLE = '{rst_reg: 1'b1, rst_esc: 1'b1, rst_byte: 1'b1,
                                    rst_pix: 1'b1, aux_en: 1'b0, esc_clk_en: 1'b0,
                                    phy_en: 1'b0, ready: 1'b0};

  // Handshake index 0 waits in the configuration state, index 1 in the byte state.
  function automatic seq_state_e hs_wait_state(input int idx);
    return (idx == 0) ? ST_CFG : ST_BYTE;
  endfunction

  function automatic logic in_teardown(input seq_state_e s);
    return (s == ST_DPIX) || (s == ST_DBYTE) || (s == ST_DESC) || (s == ST_DREG);
  endfunction

endpackage

// File: rtl/dls_gap_timer.sv
`timescale 1ns/1ps
module dls_gap_timer #(
  parameter int GAP_W   = 4,
  parameter int DEF_GAP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [GAP_W-1:0] gap_sel,
  output logic             gap_met
);
  localparam int DEF_W = $clog2(DEF_GAP + 1);
  localparam int CNT_W = ((DEF_W > GAP_W) ? DEF_W : GAP_W) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] eff_gap;
  logic [CNT_W-1:0] cnt_inc;

  always_comb begin
    if (gap_sel == '0) eff_gap = CNT_W'(DEF_GAP);
    else               eff_gap = {{(CNT_W-GAP_W){1'b0}}, gap_sel};
    cnt_inc = cnt_q + 1'b1;
    gap_met = (cnt_inc >= eff_gap);
  end

  // Counter stops once the spacing is met, so it never wraps.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (restart)  cnt_q <= '0;
    else if (!gap_met) cnt_q <= cnt_inc;
  end

endmodule

// File: rtl/dls_hs_catch.sv
`timescale 1ns/1ps
module dls_hs_catch (
  input  logic clk,
  input  logic rst_n,
  input  logic win,
  input  logic pulse,
  output logic seen,
  output logic stray
);
  logic held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   held_q <= 1'b0;
    else if (win) held_q <= held_q | pulse;
    else          held_q <= 1'b0;
  end

  assign seen  = win & (held_q | pulse);
  assign stray = pulse & ~win;

endmodule

// File: rtl/dls_ctrl.sv
`timescale 1ns/1ps
module dls_ctrl
  import dls_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_req,
  input  logic                dis_req,
  input  logic [HS_COUNT-1:0] hs_pulse,
  input  logic                gap_met,
  output seq_state_e          state_q,
  output seq_state_e          state_d,
  output logic                restart,
  output logic                order_err
);
  logic [HS_COUNT-1:0] hs_win;
  logic [HS_COUNT-1:0] hs_seen;
  logic [HS_COUNT-1:0] hs_stray;
  logic                bad_req;

  for (genvar gi = 0; gi < HS_COUNT; gi++) begin : g_hs
    assign hs_win[gi] = (state_q == hs_wait_state(gi));
    dls_hs_catch u_catch (
      .clk   (clk),
      .rst_n (rst_n),
      .win   (hs_win[gi]),
      .pulse (hs_pulse[gi]),
      .seen  (hs_seen[gi]),
      .stray (hs_stray[gi])
    );
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (en_req && !dis_req) state_d = ST_CFG;
      ST_CFG:   if (dis_req) state_d = ST_DPIX;
                else if (gap_met && hs_seen[0]) state_d = ST_ESC;
      ST_ESC:   if (dis_req) state_d = ST_DPIX;
                else if (gap_met) state_d = ST_BYTE;
      ST_BYTE:  if (dis_req) state_d = ST_DPIX;
                else if (gap_met && hs_seen[1]) state_d = ST_RUN;
      ST_RUN:   if (dis_req) state_d = ST_DPIX;
      ST_DPIX:  state_d = ST_DBYTE;
      ST_DBYTE: state_d = ST_DESC;
      ST_DESC:  state_d = ST_DREG;
      ST_DREG:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    bad_req = |hs_stray;
    if (en_req && ((state_q != ST_IDLE) || dis_req)) bad_req = 1'b1;
    if (dis_req && ((state_q == ST_IDLE) || in_teardown(state_q))) bad_req = 1'b1;
  end

  assign restart = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      order_err <= 1'b0;
    end else begin
      state_q   <= state_d;
      order_err <= bad_req;
    end
  end

  // R11
  teardown_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DREG) |=> (state_q == ST_IDLE));

  // R9
  idle_dis_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && dis_req) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/dls_out_decode.sv
`timescale 1ns/1ps
module dls_out_decode
  import dls_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_e state_d,
  output seq_out_t   out_q
);
  seq_out_t out_d;

  always_comb begin
    out_d = out_q;
    case (state_d)
      ST_IDLE: out_d = OUT_IDLE;
      ST_CFG: begin
        out_d = OUT_IDLE;
        out_d.rst_reg    = 1'b0;
        out_d.aux_en     = 1'b1;
        out_d.esc_clk_en = 1'b1;
        out_d.phy_en     = 1'b1;
      end
      ST_ESC:  out_d.rst_esc  = 1'b0;
      ST_BYTE: out_d.rst_byte = 1'b0;
      ST_RUN: begin
        out_d.rst_pix = 1'b0;
        out_d.ready   = 1'b1;
      end
      // Teardown only ever sets resets; nothing asserted is released.
      ST_DPIX: begin
        out_d.rst_pix = 1'b1;
        out_d.phy_en  = 1'b0;
        out_d.ready   = 1'b0;
        out_d.aux_en  = 1'b1;
      end
      ST_DBYTE: out_d.rst_byte = 1'b1;
      ST_DESC: begin
        out_d.rst_esc    = 1'b1;
        out_d.esc_clk_en = 1'b0;
      end
      ST_DREG: out_d.rst_reg = 1'b1;
      default: out_d = OUT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= OUT_IDLE;
    else        out_q <= out_d;
  end

  // R3
  esc_after_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_q.rst_esc) |-> (!out_q.rst_reg && $past(!out_q.rst_reg)));

  // R5
  pix_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_q.rst_pix) |-> (!out_q.rst_byte && !out_q.rst_esc && !out_q.rst_reg));

  // R7
  reg_last_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q.rst_reg) |-> (out_q.rst_esc && out_q.rst_byte && out_q.rst_pix));

  // R7
  phy_before_esc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_q.esc_clk_en) |-> (!out_q.phy_en && $past(!out_q.phy_en)));

  // R8
  aux_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_q.rst_reg || !out_q.rst_esc || !out_q.rst_byte || !out_q.rst_pix) |-> out_q.aux_en);

  // R10
  ready_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_q.ready |-> !(out_q.rst_reg || out_q.rst_esc || out_q.rst_byte || out_q.rst_pix));

endmodule

// File: rtl/dlink_rst_seq.sv
`timescale 1ns/1ps
module dlink_rst_seq
  import dls_pkg::*;
#(
  parameter int GAP_W   = 4,
  parameter int DEF_GAP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_req,
  input  logic             dis_req,
  input  logic             cfg_done,
  input  logic             cmd_done,
  input  logic [GAP_W-1:0] step_gap,
  output logic             rst_reg,
  output logic             rst_esc,
  output logic             rst_byte,
  output logic             rst_pix,
  output logic             aux_clk_en,
  output logic             esc_clk_en,
  output logic             phy_en,
  output logic             ready,
  output logic             order_err
);
  seq_state_e state_q;
  seq_state_e state_d;
  logic       restart;
  logic       gap_met;
  seq_out_t   outs;

  dls_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_req    (en_req),
    .dis_req   (dis_req),
    .hs_pulse  ({cmd_done, cfg_done}),
    .gap_met   (gap_met),
    .state_q   (state_q),
    .state_d   (state_d),
    .restart   (restart),
    .order_err (order_err)
  );

  dls_gap_timer #(.GAP_W(GAP_W), .DEF_GAP(DEF_GAP)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .gap_sel (step_gap),
    .gap_met (gap_met)
  );

  dls_out_decode u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_d (state_d),
    .out_q   (outs)
  );

  assign rst_reg    = outs.rst_reg;
  assign rst_esc    = outs.rst_esc;
  assign rst_byte   = outs.rst_byte;
  assign rst_pix    = outs.rst_pix;
  assign aux_clk_en = outs.aux_en;
  assign esc_clk_en = outs.esc_clk_en;
  assign phy_en     = outs.phy_en;
  assign ready      = outs.ready;

  // R9
  busy_enable_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_req && aux_clk_en) |=> order_err);

  // R2
  first_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && en_req && !dis_req) |=> (!rst_reg && rst_esc && rst_byte && rst_pix));

endmodule

// File: tb/tb_dlink_rst_seq.sv
`timescale 1ns/1ps
module tb_dlink_rst_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_req = 1'b0, dis_req = 1'b0, cfg_done = 1'b0, cmd_done = 1'b0;
  logic [3:0] step_gap = 4'd0;
  logic       rst_reg, rst_esc, rst_byte, rst_pix, aux_clk_en, esc_clk_en, phy_en, ready, order_err;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  dlink_rst_seq dut (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
    .cfg_done(cfg_done), .cmd_done(cmd_done), .step_gap(step_gap),
    .rst_reg(rst_reg), .rst_esc(rst_esc), .rst_byte(rst_byte), .rst_pix(rst_pix),
    .aux_clk_en(aux_clk_en), .esc_clk_en(esc_clk_en), .phy_en(phy_en),
    .ready(ready), .order_err(order_err)
  );

  wire [7:0] ov = {rst_reg, rst_esc, rst_byte, rst_pix, aux_clk_en, esc_clk_en, phy_en, ready};
  localparam logic [7:0] OV_IDLE = 8'hF0;
  localparam logic [7:0] OV_CFG  = 8'h7E;
  localparam logic [7:0] OV_RUN  = 8'h0F;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Bring-up with handshakes pulsed at index d of their wait windows.
  task automatic run_up(input int gv, input int d);
    int g = (gv == 0) ? 4 : gv;
    int t;
    step_gap = 4'(gv);
    en_req = 1'b1; tick(); en_req = 1'b0;
    chk(ov == OV_CFG, "R2 first release step", ov, OV_CFG);
    t = 0;
    while (rst_esc && t < 60) begin cfg_done = (t == d); tick(); t++; end
    cfg_done = 1'b0;
    if (gv == 0) chk(t == imax(g, d + 1), "R6 default gap on escape release", t, imax(g, d + 1));
    else         chk(t == imax(g, d + 1), "R3 escape release spacing", t, imax(g, d + 1));
    t = 0;
    while (rst_byte && t < 60) begin tick(); t++; end
    chk(t == g, "R4 byte release spacing", t, g);
    chk(ready == 1'b0, "R10 ready low before pixel release", ready, 0);
    t = 0;
    while (rst_pix && t < 60) begin cmd_done = (t == d); tick(); t++; end
    cmd_done = 1'b0;
    chk(t == imax(g, d + 1), "R5 pixel release spacing", t, imax(g, d + 1));
    chk(ov == OV_RUN, "R10 running outputs", ov, OV_RUN);
  endtask

  // Teardown; esc_pre/byte_pre say those resets were already asserted.
  task automatic run_down(input bit esc_pre, input bit byte_pre);
    logic [7:0] exp;
    dis_req = 1'b1; tick(); dis_req = 1'b0;
    for (int k = 0; k < 5; k++) begin
      exp = {(k >= 3), (esc_pre || k >= 2), (byte_pre || k >= 1), 1'b1,
             (k < 4), (k < 2), 1'b0, 1'b0};
      chk(ov == exp, (k == 4) ? "R11 idle after teardown" : "R7 teardown step", ov, exp);
      if (k == 3) chk(aux_clk_en == 1'b1, "R8 aux clock on through last step", aux_clk_en, 1);
      if (k < 4) tick();
    end
    chk(order_err == 1'b0, "R9 no flag on legal teardown", order_err, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int gaps[6] = '{0, 1, 2, 3, 5, 7};
    int dls[3]  = '{0, 2, 6};
    repeat (3) tick();
    chk(ov == OV_IDLE && order_err == 1'b0, "R1 state in reset", ov, OV_IDLE);
    rst_n = 1'b1;
    tick(); tick();
    chk(ov == OV_IDLE && order_err == 1'b0, "R1 state after reset", ov, OV_IDLE);

    // R9: wrong-order requests in idle
    dis_req = 1'b1; tick(); dis_req = 1'b0;
    chk(order_err == 1'b1 && ov == OV_IDLE, "R9 disable in idle flagged", order_err, 1);
    tick();
    chk(order_err == 1'b0, "R9 flag lasts one cycle", order_err, 0);
    en_req = 1'b1; dis_req = 1'b1; tick(); en_req = 1'b0; dis_req = 1'b0;
    chk(order_err == 1'b1 && ov == OV_IDLE, "R9 enable with disable ignored", ov, OV_IDLE);
    cfg_done = 1'b1; tick(); cfg_done = 1'b0;
    chk(order_err == 1'b1 && ov == OV_IDLE, "R9 early cfg_done flagged", order_err, 1);
    tick();

    // Sweep of gap settings and handshake delays
    foreach (gaps[gi]) begin
      foreach (dls[di]) begin
        run_up(gaps[gi], dls[di]);
        run_down(1'b0, 1'b0);
        tick();
      end
    end

    // R9: wrong-order requests while running
    run_up(2, 0);
    en_req = 1'b1; tick(); en_req = 1'b0;
    chk(order_err == 1'b1 && ov == OV_RUN, "R9 enable while running ignored", ov, OV_RUN);
    cfg_done = 1'b1; tick(); cfg_done = 1'b0;
    chk(order_err == 1'b1 && ov == OV_RUN, "R9 cfg_done while running ignored", ov, OV_RUN);
    run_down(1'b0, 1'b0);
    tick();

    // R9: stray cmd_done during escape step is forgotten
    step_gap = 4'd2;
    en_req = 1'b1; tick(); en_req = 1'b0;
    cfg_done = 1'b1; tick(); cfg_done = 1'b0;
    tick();
    chk(rst_esc == 1'b0 && rst_byte == 1'b1, "R3 escape released at gap", rst_esc, 0);
    cmd_done = 1'b1; tick(); cmd_done = 1'b0;
    chk(order_err == 1'b1, "R9 stray cmd_done flagged", order_err, 1);
    tick();
    chk(rst_byte == 1'b0, "R4 byte released", rst_byte, 0);
    repeat (5) tick();
    chk(rst_pix == 1'b1 && ready == 1'b0, "R9 stray cmd_done not remembered", rst_pix, 1);
    cmd_done = 1'b1; tick(); cmd_done = 1'b0;
    chk(rst_pix == 1'b0 && ready == 1'b1, "R5 pixel released on fresh cmd_done", rst_pix, 0);
    dis_req = 1'b1; tick(); dis_req = 1'b0;
    dis_req = 1'b1; tick(); dis_req = 1'b0;
    chk(order_err == 1'b1 && rst_byte == 1'b1, "R9 disable during teardown flagged", order_err, 1);
    repeat (4) tick();
    chk(ov == OV_IDLE, "R11 idle despite repeated disable", ov, OV_IDLE);

    // R11: abort from the configuration wait
    step_gap = 4'd3;
    en_req = 1'b1; tick(); en_req = 1'b0;
    chk(ov == OV_CFG, "R2 release before abort", ov, OV_CFG);
    run_down(1'b1, 1'b1);
    tick();
    chk(ov == OV_IDLE && order_err == 1'b0, "R11 stays idle", ov, OV_IDLE);

    report();
  end
endmodule